// File: doc/BRIEF.md
# Multiplexed Parallel Bus Memory Target

This block is the target side of a 32-bit parallel bus whose address and data share one set of lines. A master starts a transaction by pulling `frame_n` low for one address cycle. The block captures the address and the command there. If the address lies in its 256-byte window and the command is a memory read or a memory write, the block claims the transaction with `devsel_n` using medium decode timing. It then serves data phases from a file of 64 words of 32 bits, using the `irdy_n`/`trdy_n` handshake.

Bursts walk the word index upward, one word per completed phase. A burst that would run past the last word of the window is cut short. The target first disconnects with data on that last word, and if the master keeps going it then disconnects without data. Write data is checked for even parity, and errors are reported on `perr_n`. Read data gets a parity bit one cycle later.

The bus is modelled as split input, output and enable pins, so the block sits inside a chip with the pad or tristate logic outside it. The `BURST_EN` parameter set to 0 turns the block into a single-word target that disconnects on its first data phase.

Top module: `mbus_target`

## Requirements
- R1: An address cycle is a clock where `frame_n` is sampled low while it was high on the previous clock and the target is idle. The target claims only when `ad_in[31:8]` equals `BASE_ADDR[31:8]` and `cbe_n` is 4'b0110 (memory read) or 4'b0111 (memory write). In every other case `devsel_n` stays high, `ctl_oe` stays low and no stored word changes.
- R2: After a claimed address cycle, `devsel_n` is high in the first following cycle and low from the second following cycle on.
- R3: A data phase completes only on a clock where both `irdy_n` and `trdy_n` are low. A write stores the `ad_in` word present on that clock into word `ad[7:2]` of the address. Byte b is written only when `cbe_n[b]` is low. Cycles with `irdy_n` high store nothing.
- R4: During a read, `ad_oe` is low in the first cycle after the address cycle, which is the bus turnaround. From the second cycle on it is high, and `ad_out` carries the currently indexed word.
- R5: Each completed data phase advances the word index by one, so bursts are linear.
- R6: A data phase that completes with `frame_n` high is the last one. In the next cycle `devsel_n`, `trdy_n` and `stop_n` are driven high with `ctl_oe` high. In the cycle after that, `ctl_oe` is low.
- R7: The data phase that addresses word 63 has `stop_n` low together with `trdy_n` low (disconnect with data). Earlier phases have `stop_n` high.
- R8: If `frame_n` is still low when that phase completes, the target drives `stop_n` low with `trdy_n` high and `devsel_n` low until it samples `frame_n` high. No data is transferred in those cycles, and the index never wraps to word 0.
- R9: Write parity is even over `ad_in`, `cbe_n` and `par_in`, with `par_in` arriving one cycle after its data. A parity failure on a completed write phase drives `perr_n` low for exactly the cycle that starts two clocks after that phase. `perr_n` is high otherwise.
- R10: In the cycle after each cycle with `ad_oe` high, `par_oe` is high and `par_out` gives even parity over that cycle's `ad_out` and `cbe_n`.
- R11: While reset is asserted and after it is released, the target is idle: `devsel_n`, `trdy_n`, `stop_n` and `perr_n` are high, and `ctl_oe`, `ad_oe` and `par_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction framing from master, active low |
| irdy_n | input | 1 | Master ready, active low |
| ad_in | input | 32 | Address/data lines as seen by the target |
| cbe_n | input | 4 | Command in address cycle, active-low byte enables in data cycles |
| par_in | input | 1 | Parity from master, one cycle behind its data |
| ad_out | output | 32 | Read data driven onto the shared lines |
| ad_oe | output | 1 | Enable for `ad_out` |
| par_out | output | 1 | Parity for read data, one cycle behind it |
| par_oe | output | 1 | Enable for `par_out` |
| devsel_n | output | 1 | Transaction claimed, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |
| ctl_oe | output | 1 | Enable for `devsel_n`, `trdy_n` and `stop_n` |
| perr_n | output | 1 | Data parity error report, active low |

## Verification
Two functions can land on the same clock: the window-end disconnect and the master's own last data phase. They collide when a transfer addresses word 63 with `frame_n` already high. The bench provokes this with a one-word write to word 63 and with a two-word read ending on word 63. It judges the result by `stop_n` and `trdy_n` both being low on that phase, followed directly by the release cycle and the tristate cycle, with no stop-without-data cycle in between. A longer burst over the same boundary is the contrast case. In that case the extra cycle must appear, and word 0 must read back unchanged.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_DATA,
    ST_STOPW,
    ST_TURN,
    ST_SKIP
  } tgt_state_t;

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int          IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic [31:0]      ad_in,
  input  logic [3:0]       cbe_n,
  output logic             hit_q,
  output logic             wr_q,
  output logic [IDX_W-1:0] idx_q
);
  import mbt_pkg::*;

  localparam int WIN_LSB = IDX_W + 2;

  logic             win_match;
  logic             cmd_rd;
  logic             cmd_wr;
  logic             hit_d;
  logic [IDX_W-1:0] idx_d;
  logic             unused_low_bits;

  always_comb begin
    win_match = (ad_in[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB]);
    cmd_rd    = (cbe_n == CMD_MEM_RD);
    cmd_wr    = (cbe_n == CMD_MEM_WR);
    hit_d     = win_match && (cmd_rd || cmd_wr);
    idx_d     = ad_in[WIN_LSB-1:2];
  end

  assign unused_low_bits = ^ad_in[1:0];

  // Capture only on the address cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      wr_q  <= 1'b0;
      idx_q <= '0;
    end else if (addr_phase) begin
      hit_q <= hit_d;
      wr_q  <= cmd_wr;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wbe,
  input  logic [IDX_W-1:0]    ridx,
  output logic [DATA_W-1:0]   rdata
);
  localparam int NBYTES = DATA_W / 8;

  logic [DEPTH-1:0][DATA_W-1:0] words;

  for (genvar e = 0; e < DEPTH; e++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              sel;

    assign sel = we && (widx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (sel) begin
        for (int b = 0; b < NBYTES; b++) begin
          if (wbe[b]) word_q[b*8 +: 8] <= wdata[b*8 +: 8];
        end
      end
    end

    assign words[e] = word_q;
  end

  assign rdata = words[ridx];

endmodule

// File: rtl/mbt_parity.sv
module mbt_parity #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   ad_in,
  input  logic [DATA_W/8-1:0] cbe_n,
  input  logic                par_in,
  input  logic                wr_done,
  input  logic [DATA_W-1:0]   ad_out,
  input  logic                ad_oe,
  output logic                perr_n,
  output logic                par_out,
  output logic                par_oe
);
  logic [DATA_W-1:0]   ad_q;
  logic [DATA_W/8-1:0] cbe_q;
  logic                chk_pend_q;
  logic                bad_d;
  logic                perr_n_d;
  logic                par_d;

  always_comb begin
    bad_d    = ^{ad_q, cbe_q, par_in};
    perr_n_d = !(chk_pend_q && bad_d);
    par_d    = ^{ad_out, cbe_n};
  end

  // Bus word captured every clock; only a completed write arms the check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q       <= '0;
      cbe_q      <= '0;
      chk_pend_q <= 1'b0;
      perr_n     <= 1'b1;
      par_out    <= 1'b0;
      par_oe     <= 1'b0;
    end else begin
      ad_q       <= ad_in;
      cbe_q      <= cbe_n;
      chk_pend_q <= wr_done;
      perr_n     <= perr_n_d;
      par_out    <= par_d;
      par_oe     <= ad_oe;
    end
  end

endmodule

// File: rtl/mbt_ctrl.sv
module mbt_ctrl #(
  parameter int IDX_W    = 6,
  parameter bit BURST_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             hit,
  input  logic             is_wr,
  input  logic [IDX_W-1:0] idx_start,
  output logic             addr_phase,
  output logic             xfer,
  output logic             xfer_wr,
  output logic [IDX_W-1:0] idx_q,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             ctl_oe,
  output logic             ad_oe
);
  import mbt_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  tgt_state_t       state_q;
  tgt_state_t       state_d;
  logic             frame_q;
  logic [IDX_W-1:0] idx_d;
  logic             at_stop;
  logic             devsel_n_d;
  logic             trdy_n_d;
  logic             stop_n_d;
  logic             ctl_oe_d;
  logic             ad_oe_d;

  assign addr_phase = (state_q == ST_IDLE) && !frame_n && frame_q;
  assign xfer       = !trdy_n && !irdy_n;
  assign xfer_wr    = xfer && is_wr;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE:   if (addr_phase) state_d = ST_DECODE;
      ST_DECODE: begin
        state_d = hit ? ST_DATA : ST_SKIP;
        idx_d   = idx_start;
      end
      ST_DATA: begin
        if (xfer) begin
          if (frame_n)      state_d = ST_TURN;
          else if (!stop_n) state_d = ST_STOPW;
          else begin
            state_d = ST_DATA;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      ST_STOPW:  if (frame_n) state_d = ST_TURN;
      ST_TURN:   state_d = ST_IDLE;
      ST_SKIP:   if (frame_n && irdy_n) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  if (BURST_EN) begin : g_burst
    assign at_stop = (idx_d == LAST_IDX);
  end else begin : g_single
    logic unused_idx;
    assign unused_idx = ^idx_d;
    assign at_stop    = 1'b1;
  end

  always_comb begin
    devsel_n_d = !((state_d == ST_DATA) || (state_d == ST_STOPW));
    trdy_n_d   = (state_d != ST_DATA);
    stop_n_d   = !(((state_d == ST_DATA) && at_stop) || (state_d == ST_STOPW));
    ctl_oe_d   = (state_d == ST_DATA) || (state_d == ST_STOPW) || (state_d == ST_TURN);
    ad_oe_d    = (state_d == ST_DATA) && !is_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      frame_q  <= 1'b1;
      idx_q    <= '0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ctl_oe   <= 1'b0;
      ad_oe    <= 1'b0;
    end else begin
      state_q  <= state_d;
      frame_q  <= frame_n;
      idx_q    <= idx_d;
      devsel_n <= devsel_n_d;
      trdy_n   <= trdy_n_d;
      stop_n   <= stop_n_d;
      ctl_oe   <= ctl_oe_d;
      ad_oe    <= ad_oe_d;
    end
  end

endmodule

// File: rtl/mbus_target.sv
module mbus_target #(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int          NUM_WORDS = 64,
  parameter int          DATA_W    = 32,
  parameter bit          BURST_EN  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic [DATA_W-1:0]   ad_in,
  input  logic [DATA_W/8-1:0] cbe_n,
  input  logic                par_in,
  output logic [DATA_W-1:0]   ad_out,
  output logic                ad_oe,
  output logic                par_out,
  output logic                par_oe,
  output logic                devsel_n,
  output logic                trdy_n,
  output logic                stop_n,
  output logic                ctl_oe,
  output logic                perr_n
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             addr_phase;
  logic             hit;
  logic             is_wr;
  logic [IDX_W-1:0] idx_start;
  logic [IDX_W-1:0] idx_q;
  logic             xfer;
  logic             xfer_wr;
  logic             unused_xfer;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n     = rst_sync_q[1];
  assign unused_xfer = xfer;

  mbt_decode #(
    .BASE_ADDR(BASE_ADDR),
    .IDX_W    (IDX_W)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .addr_phase(addr_phase),
    .ad_in     (ad_in),
    .cbe_n     (cbe_n),
    .hit_q     (hit),
    .wr_q      (is_wr),
    .idx_q     (idx_start)
  );

  mbt_ctrl #(
    .IDX_W   (IDX_W),
    .BURST_EN(BURST_EN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .hit       (hit),
    .is_wr     (is_wr),
    .idx_start (idx_start),
    .addr_phase(addr_phase),
    .xfer      (xfer),
    .xfer_wr   (xfer_wr),
    .idx_q     (idx_q),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .ctl_oe    (ctl_oe),
    .ad_oe     (ad_oe)
  );

  mbt_regfile #(
    .DEPTH (NUM_WORDS),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_s_n),
    .we   (xfer_wr),
    .widx (idx_q),
    .wdata(ad_in),
    .wbe  (~cbe_n),
    .ridx (idx_q),
    .rdata(ad_out)
  );

  mbt_parity #(
    .DATA_W(DATA_W)
  ) u_parity (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .ad_in  (ad_in),
    .cbe_n  (cbe_n),
    .par_in (par_in),
    .wr_done(xfer_wr),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .perr_n (perr_n),
    .par_out(par_out),
    .par_oe (par_oe)
  );

endmodule

// File: rtl/mbt_chk.sv
module mbt_chk #(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int          NUM_WORDS = 64,
  parameter int          DATA_W    = 32
) (
  input logic                clk,
  input logic                rst_s_n,
  input logic                addr_phase,
  input logic                frame_n,
  input logic                irdy_n,
  input logic [DATA_W-1:0]   ad_in,
  input logic [DATA_W/8-1:0] cbe_n,
  input logic [DATA_W-1:0]   ad_out,
  input logic                ad_oe,
  input logic                par_out,
  input logic                par_oe,
  input logic                devsel_n,
  input logic                trdy_n,
  input logic                stop_n,
  input logic                ctl_oe,
  input logic                perr_n
);
  localparam int WIN_LSB = $clog2(NUM_WORDS) + 2;

  logic in_win;
  logic cmd_ok;
  logic unused_frame;

  assign in_win       = (ad_in[DATA_W-1:WIN_LSB] == BASE_ADDR[DATA_W-1:WIN_LSB]);
  assign cmd_ok       = (cbe_n == 4'b0110) || (cbe_n == 4'b0111);
  assign unused_frame = frame_n;

  assert_medium_claim_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    addr_phase && in_win && cmd_ok |=> devsel_n ##1 !devsel_n);

  assert_ignore_other_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    addr_phase && !(in_win && cmd_ok) |=> devsel_n && !ctl_oe ##1 devsel_n && !ctl_oe);

  assert_trdy_claimed_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !trdy_n |-> !devsel_n && ctl_oe);

  assert_nodata_stop_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !stop_n && trdy_n |-> !devsel_n && ctl_oe);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    ctl_oe && $rose(devsel_n) |=> !ctl_oe);

  assert_perr_source_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !perr_n |-> $past(!irdy_n && !trdy_n && !ad_oe, 2));

  assert_read_parity_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    par_oe |-> ((^{$past(ad_out), $past(cbe_n), par_out}) == 1'b0));

endmodule

bind mbus_target mbt_chk #(
  .BASE_ADDR(BASE_ADDR),
  .NUM_WORDS(NUM_WORDS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .addr_phase(addr_phase),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .ad_in     (ad_in),
  .cbe_n     (cbe_n),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .par_out   (par_out),
  .par_oe    (par_oe),
  .devsel_n  (devsel_n),
  .trdy_n    (trdy_n),
  .stop_n    (stop_n),
  .ctl_oe    (ctl_oe),
  .perr_n    (perr_n)
);

// File: tb/test_mbus_target.sv
`timescale 1ns/1ps
module test_mbus_target;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [3:0]  RD   = 4'b0110;
  localparam logic [3:0]  WR   = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, par_in;
  logic [31:0] ad_in;
  logic [3:0]  cbe_n;
  logic [31:0] ad_out;
  logic        ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, ctl_oe, perr_n;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] mdl [64];
  logic [31:0] wdata [8];
  logic [31:0] prev_ad;
  logic [3:0]  prev_cbe;
  bit          corrupt_prev, d1, d2, rp_prev, rp_exp;

  always #10 clk = ~clk;

  mbus_target #(.BASE_ADDR(BASE)) i_mbus_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_in(ad_in), .cbe_n(cbe_n), .par_in(par_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .ctl_oe(ctl_oe), .perr_n(perr_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance to the next sampling point and run the pipelined parity checks
  task automatic step();
    @(negedge clk);
    chk(perr_n === !d2, "R9 perr_n timing", {31'b0, perr_n}, {31'b0, !d2});
    d2 = d1;
    d1 = 1'b0;
    if (rp_prev)
      chk(par_oe === 1'b1 && par_out === rp_exp, "R10 read parity",
          {30'b0, par_oe, par_out}, {30'b0, 1'b1, rp_exp});
    par_in = (^{prev_ad, prev_cbe}) ^ corrupt_prev;
  endtask

  task automatic endit(input bit bad);
    prev_ad      = ad_in;
    prev_cbe     = cbe_n;
    corrupt_prev = bad;
    d1           = bad;
    rp_prev      = ad_oe;
    rp_exp       = ^{ad_out, cbe_n};
  endtask

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [3:0] cmd,
                      input int n, input int wait_at, input int bad_at,
                      input logic [3:0] be, input bit claim, input string tag);
    int i = 0, cyc = 0, tail = 0, wt = 0, idx;
    bit over = 0, stopw = 0, fin = 0, bad;
    idx = int'(addr[7:2]);
    step();
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    endit(1'b0);
    while (!fin) begin
      step();
      cyc++;
      bad = 1'b0;
      if (cyc == 1) begin
        chk(devsel_n === 1'b1, {tag, " R2 no claim in first cycle"}, {31'b0, devsel_n}, 32'd1);
        if (claim && !wr) chk(ad_oe === 1'b0, {tag, " R4 turnaround"}, {31'b0, ad_oe}, 32'd0);
      end
      if (cyc == 2)
        chk(devsel_n === !claim, {tag, " R2 medium claim"}, {31'b0, devsel_n}, {31'b0, !claim});
      if (!claim) begin
        chk(ctl_oe === 1'b0 && devsel_n === 1'b1, {tag, " R1 not claimed"},
            {30'b0, ctl_oe, devsel_n}, 32'b01);
        frame_n = 1'b1; irdy_n = (cyc >= 4); ad_in = wdata[0]; cbe_n = be;
        if (cyc == 5) fin = 1;
      end else if (over) begin
        if (tail == 0)
          chk(ctl_oe === 1'b1 && devsel_n === 1'b1 && trdy_n === 1'b1 && stop_n === 1'b1,
              {tag, " R6 release"}, {28'b0, ctl_oe, devsel_n, trdy_n, stop_n}, 32'hF);
        else if (tail == 1)
          chk(ctl_oe === 1'b0, {tag, " R6 tristate"}, {31'b0, ctl_oe}, 32'd0);
        frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0;
        tail++;
        if (tail == 3) fin = 1;
      end else if (stopw) begin
        chk(stop_n === 1'b0 && trdy_n === 1'b1 && devsel_n === 1'b0, {tag, " R8 stop without data"},
            {29'b0, stop_n, trdy_n, devsel_n}, 32'b010);
        frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'hBAD0_0000; cbe_n = be;
        over = 1;
      end else if (wait_at == i && wt < 2 && cyc >= 2) begin
        irdy_n = 1'b1; frame_n = 1'b0; ad_in = 32'h5A5A_0000 + wt; cbe_n = be;
        wt++;
      end else begin
        irdy_n = 1'b0; frame_n = (i == n - 1); ad_in = wr ? wdata[i] : 32'h0; cbe_n = be;
        if (trdy_n === 1'b0) begin
          chk(stop_n === ((idx == 63) ? 1'b0 : 1'b1), {tag, " R7 stop with data"},
              {31'b0, stop_n}, {31'b0, (idx != 63)});
          if (wr) begin
            for (int b = 0; b < 4; b++)
              if (!be[b]) mdl[idx][b*8 +: 8] = wdata[i][b*8 +: 8];
            bad = (i == bad_at);
          end else begin
            chk(ad_oe === 1'b1 && ad_out === mdl[idx], {tag, " R4 R5 read word"}, ad_out, mdl[idx]);
          end
          if (idx == 63 && i != n - 1) stopw = 1;
          else if (i == n - 1) over = 1;
          i++;
          idx++;
        end
      end
      endit(bad);
    end
    frame_n = 1'b1; irdy_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = '0; par_in = 1'b0;
    prev_ad = '0; prev_cbe = '0; corrupt_prev = 0; d1 = 0; d2 = 0; rp_prev = 0; rp_exp = 0;
    for (int k = 0; k < 64; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    chk(devsel_n === 1 && trdy_n === 1 && stop_n === 1 && perr_n === 1 &&
        ctl_oe === 0 && ad_oe === 0 && par_oe === 0, "R11 in reset",
        {25'b0, devsel_n, trdy_n, stop_n, perr_n, ctl_oe, ad_oe, par_oe}, 32'h78);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(devsel_n === 1 && trdy_n === 1 && stop_n === 1 && perr_n === 1 &&
        ctl_oe === 0 && ad_oe === 0 && par_oe === 0, "R11 after release",
        {25'b0, devsel_n, trdy_n, stop_n, perr_n, ctl_oe, ad_oe, par_oe}, 32'h78);
  endtask

  task automatic t_single();
    wdata[0] = 32'h1234_5678;
    xfer(1, BASE | (32'd5 << 2), WR, 1, -1, -1, 4'b0000, 1, "single wr R3");
    xfer(0, BASE | (32'd5 << 2), RD, 1, -1, -1, 4'b0000, 1, "single rd R3");
  endtask

  task automatic t_burst();
    for (int k = 0; k < 4; k++) wdata[k] = 32'hA000_0000 + 32'h0101_0101 * k;
    xfer(1, BASE | (32'd10 << 2), WR, 4, -1, -1, 4'b0000, 1, "burst wr R5");
    wdata[0] = 32'hFFEE_DDCC;
    xfer(1, BASE | (32'd11 << 2), WR, 1, -1, -1, 4'b1010, 1, "byte enables R3");
    xfer(0, BASE | (32'd10 << 2), RD, 4, -1, -1, 4'b0000, 1, "burst rd R5");
  endtask

  task automatic t_wait();
    for (int k = 0; k < 3; k++) wdata[k] = 32'hC0DE_0000 + k;
    xfer(1, BASE | (32'd20 << 2), WR, 3, 1, -1, 4'b0000, 1, "wait wr R3");
    xfer(0, BASE | (32'd20 << 2), RD, 3, 2, -1, 4'b0000, 1, "wait rd R3");
  endtask

  task automatic t_ignored();
    wdata[0] = 32'hDEAD_BEEF;
    xfer(1, BASE | (32'd30 << 2), 4'b0010, 1, -1, -1, 4'b0000, 0, "bad cmd R1");
    xfer(1, 32'h4000_0100 | (32'd30 << 2), WR, 1, -1, -1, 4'b0000, 0, "out of window R1");
    xfer(0, BASE | (32'd30 << 2), RD, 1, -1, -1, 4'b0000, 1, "untouched R1");
  endtask

  task automatic t_window_end();
    for (int k = 0; k < 4; k++) wdata[k] = 32'h6300_0000 + k;
    xfer(1, BASE | (32'd62 << 2), WR, 4, -1, -1, 4'b0000, 1, "edge wr R7 R8");
    xfer(0, BASE | (32'd0 << 2), RD, 1, -1, -1, 4'b0000, 1, "no wrap R8");
    xfer(0, BASE | (32'd63 << 2), RD, 3, -1, -1, 4'b0000, 1, "edge rd R8");
    xfer(0, BASE | (32'd62 << 2), RD, 2, -1, -1, 4'b0000, 1, "edge rd coincide R7");
  endtask

  task automatic t_parity();
    for (int k = 0; k < 3; k++) wdata[k] = 32'h0F0F_0000 + k;
    xfer(1, BASE | (32'd40 << 2), WR, 3, -1, 1, 4'b0000, 1, "bad parity R9");
    wdata[0] = 32'h7777_0001;
    xfer(1, BASE | (32'd44 << 2), WR, 1, -1, 0, 4'b0011, 1, "bad parity last R9");
    xfer(0, BASE | (32'd40 << 2), RD, 3, -1, -1, 4'b0000, 1, "parity rd R10");
  endtask

  task automatic t_coincide();
    wdata[0] = 32'h3F3F_3F3F;
    xfer(1, BASE | (32'd63 << 2), WR, 1, -1, -1, 4'b0000, 1, "coincide wr R6 R7");
    xfer(0, BASE | (32'd63 << 2), RD, 1, -1, -1, 4'b0000, 1, "coincide rd R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_burst();
    t_wait();
    t_ignored();
    t_window_end();
    t_parity();
    t_coincide();
    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule